// File: doc/BRIEF.md
# Dual-Pool Physical Register Free List

This block keeps track of which physical registers a renaming pipeline may hand out next. It has two independent pools, one for integer registers and one for floating-point registers. Both pools draw from a single index space: integer registers occupy the low indices, and floating-point registers follow directly after the last integer index. Each pool is a first-in, first-out queue. A register that is released waits behind every register released before it.

The rename stage takes one register per cycle from each pool through a valid/ready allocate port. The index is presented combinationally from the head of the pool, and the head is removed when the handshake completes. Retirement gives registers back in one of two ways. A shared release port decodes the index to find the owning pool, and it discards out-of-range values and the hard-wired zero registers. Two direct release ports write into a named pool without any filtering. Each pool reports an empty flag and a free count. It also raises a one-cycle error pulse on an allocate request while empty and on a release that finds no room.

At reset, the integer pool holds the indices above the architectural integer registers, and the floating-point pool holds the indices above the architectural floating-point registers. The low indices of each range therefore start out mapped to architectural state.

Top module: `regfree_dual_pool`

## Requirements
- R1: After reset, the integer pool holds NUM_INT-NUM_LOG_INT entries in ascending order starting at NUM_LOG_INT. The floating-point pool holds NUM_FP-NUM_LOG_FP entries in ascending order starting at NUM_INT+NUM_LOG_FP. All error outputs are 0.
- R2: Each pool returns indices in the order they entered it. Released indices come out after every entry already queued.
- R3: On the shared release port, an index below NUM_INT enters the integer pool. An index from NUM_INT up to NUM_INT+NUM_FP-1 enters the floating-point pool. An index of NUM_INT+NUM_FP or above enters neither pool.
- R4: On the shared release port, index ZERO_REG changes neither pool.
- R5: When FP_ZERO_FILTER is 1, index ZERO_REG+NUM_INT on the shared release port changes neither pool.
- R6: The direct integer and floating-point release ports enqueue any index into their own pool, with no range check and no zero filtering.
- R7: The free count of each pool equals the number of queued entries and never exceeds the pool depth. The empty flag is 1 exactly when the count is 0.
- R8: The allocate ready output is 1 whenever the pool is not empty. The allocate index shows the pool head in the same cycle. An entry is removed only on a cycle where valid and ready are both 1.
- R9: An allocate request on an empty pool removes nothing. It raises that pool's allocate error output for exactly the following cycle.
- R10: An allocation and a release on the same pool in the same cycle both take effect, and the count is unchanged.
- R11: A release that finds a full pool is dropped and raises that pool's overflow output for the following cycle. When the shared and direct ports push to the same pool in one cycle with room for only one entry, the shared-port index is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_alloc_valid | input | 1 | Integer allocate request |
| int_alloc_ready | output | 1 | Integer pool can supply a register |
| int_alloc_idx | output | IDX_W | Integer register handed out |
| fp_alloc_valid | input | 1 | Floating-point allocate request |
| fp_alloc_ready | output | 1 | Floating-point pool can supply a register |
| fp_alloc_idx | output | IDX_W | Floating-point register handed out |
| rel_valid | input | 1 | Shared release strobe |
| rel_idx | input | IDX_W | Index on the shared release port |
| int_rel_valid | input | 1 | Direct integer release strobe |
| int_rel_idx | input | IDX_W | Index on the direct integer release port |
| fp_rel_valid | input | 1 | Direct floating-point release strobe |
| fp_rel_idx | input | IDX_W | Index on the direct floating-point release port |
| int_empty | output | 1 | Integer pool is empty |
| int_free_cnt | output | INT_CNT_W | Number of free integer registers |
| fp_empty | output | 1 | Floating-point pool is empty |
| fp_free_cnt | output | FP_CNT_W | Number of free floating-point registers |
| int_alloc_err | output | 1 | Integer allocate attempted while empty |
| fp_alloc_err | output | 1 | Floating-point allocate attempted while empty |
| int_ovf_err | output | 1 | Integer release dropped because the pool was full |
| fp_ovf_err | output | 1 | Floating-point release dropped because the pool was full |

## Verification
The bench targets the decode boundaries of the shared port: the last integer index, the first floating-point index, both zero registers, and indices above the total. A wrong comparison there would put registers in the wrong pool or leak a zero register into circulation. It drains a pool to empty and then requests once more. A design that pops anyway would wrap its read pointer and hand out stale indices. It also completes an allocate and a release in the same cycle, which a design with a wrong count update would see drift. Finally, it fills a pool with two simultaneous pushes and room for one. A design with the wrong priority, or with no full check, would keep the wrong index or overwrite the head.

// File: rtl/regfree_pkg.sv
package regfree_pkg;

    // Destination chosen for an index on the shared release port
    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_INT  = 2'd1,
        DEST_FP   = 2'd2
    } rel_dest_e;

endpackage

// File: rtl/regfree_release_router.sv
module regfree_release_router
    import regfree_pkg::*;
#(
    parameter int IDX_W          = 5,
    parameter int NUM_INT        = 16,
    parameter int NUM_FP         = 12,
    parameter int ZERO_REG       = 0,
    parameter bit FP_ZERO_FILTER = 1'b1
) (
    input  logic             rel_vld,
    input  logic [IDX_W-1:0] rel_idx,
    output rel_dest_e        dest
);

    localparam int EXT_W = IDX_W + 1;
    localparam logic [EXT_W-1:0] INT_LIMIT = EXT_W'(NUM_INT);
    localparam logic [EXT_W-1:0] ALL_LIMIT = EXT_W'(NUM_INT + NUM_FP);
    localparam logic [EXT_W-1:0] INT_ZERO  = EXT_W'(ZERO_REG);
    localparam logic [EXT_W-1:0] FP_ZERO   = EXT_W'(ZERO_REG + NUM_INT);

    logic [EXT_W-1:0] idx_ext;
    logic             below_int;
    logic             below_all;

    always_comb begin
        idx_ext   = {1'b0, rel_idx};
        below_int = idx_ext < INT_LIMIT;
        below_all = idx_ext < ALL_LIMIT;
        dest      = DEST_NONE;
        if (rel_vld) begin
            if (below_int) begin
                if (idx_ext != INT_ZERO) begin
                    dest = DEST_INT;
                end
            end else if (below_all) begin
                if (!(FP_ZERO_FILTER && (idx_ext == FP_ZERO))) begin
                    dest = DEST_FP;
                end
            end
        end
    end

endmodule

// File: rtl/regfree_pool.sv
module regfree_pool #(
    parameter int DEPTH     = 16,
    parameter int IDX_W     = 5,
    parameter int PRELOAD   = 8,
    parameter int FIRST_IDX = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pop_req,
    output logic [IDX_W-1:0]           head_idx,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       push0_vld,
    input  logic [IDX_W-1:0]           push0_idx,
    input  logic                       push1_vld,
    input  logic [IDX_W-1:0]           push1_idx,
    output logic                       under_err,
    output logic                       over_err
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ROOM_W = CNT_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] slots;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
        logic                        under;
        logic                        over;
    } pool_st_t;

    pool_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic pool_st_t reset_state();
        pool_st_t r;
        for (int i = 0; i < DEPTH; i++) begin
            r.slots[i] = (i < PRELOAD) ? IDX_W'(FIRST_IDX + i) : '0;
        end
        r.rd    = '0;
        r.wr    = PTR_W'(PRELOAD % DEPTH);
        r.cnt   = CNT_W'(PRELOAD);
        r.under = 1'b0;
        r.over  = 1'b0;
        return r;
    endfunction

    logic              do_pop;
    logic              acc0, acc1;
    logic [ROOM_W-1:0] room;
    logic [ROOM_W-1:0] need1;
    logic [PTR_W-1:0]  wp;

    always_comb begin
        st_d   = st_q;
        do_pop = pop_req && (st_q.cnt != '0);
        room   = ROOM_W'(DEPTH) - {1'b0, st_q.cnt} + ROOM_W'(do_pop);
        acc0   = push0_vld && (room != '0);
        need1  = acc0 ? ROOM_W'(2) : ROOM_W'(1);
        acc1   = push1_vld && (room >= need1);

        st_d.under = pop_req && (st_q.cnt == '0);
        st_d.over  = (push0_vld && !acc0) || (push1_vld && !acc1);

        if (do_pop) begin
            st_d.rd = bump(st_q.rd);
        end

        wp = st_q.wr;
        if (acc0) begin
            st_d.slots[wp] = push0_idx;
            wp = bump(wp);
        end
        if (acc1) begin
            st_d.slots[wp] = push1_idx;
            wp = bump(wp);
        end
        st_d.wr  = wp;
        st_d.cnt = st_q.cnt + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign head_idx  = st_q.slots[st_q.rd];
    assign empty     = (st_q.cnt == '0);
    assign count     = st_q.cnt;
    assign under_err = st_q.under;
    assign over_err  = st_q.over;

endmodule

// File: rtl/regfree_dual_pool.sv
module regfree_dual_pool
    import regfree_pkg::*;
#(
    parameter int NUM_INT        = 16,
    parameter int NUM_FP         = 12,
    parameter int NUM_LOG_INT    = 8,
    parameter int NUM_LOG_FP     = 8,
    parameter int ZERO_REG       = 0,
    parameter bit FP_ZERO_FILTER = 1'b1,
    parameter int IDX_W          = $clog2(NUM_INT + NUM_FP),
    parameter int INT_CNT_W      = $clog2(NUM_INT + 1),
    parameter int FP_CNT_W       = $clog2(NUM_FP + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 int_alloc_valid,
    output logic                 int_alloc_ready,
    output logic [IDX_W-1:0]     int_alloc_idx,
    input  logic                 fp_alloc_valid,
    output logic                 fp_alloc_ready,
    output logic [IDX_W-1:0]     fp_alloc_idx,
    input  logic                 rel_valid,
    input  logic [IDX_W-1:0]     rel_idx,
    input  logic                 int_rel_valid,
    input  logic [IDX_W-1:0]     int_rel_idx,
    input  logic                 fp_rel_valid,
    input  logic [IDX_W-1:0]     fp_rel_idx,
    output logic                 int_empty,
    output logic [INT_CNT_W-1:0] int_free_cnt,
    output logic                 fp_empty,
    output logic [FP_CNT_W-1:0]  fp_free_cnt,
    output logic                 int_alloc_err,
    output logic                 fp_alloc_err,
    output logic                 int_ovf_err,
    output logic                 fp_ovf_err
);

    rel_dest_e rel_dest;

    regfree_release_router #(
        .IDX_W          (IDX_W),
        .NUM_INT        (NUM_INT),
        .NUM_FP         (NUM_FP),
        .ZERO_REG       (ZERO_REG),
        .FP_ZERO_FILTER (FP_ZERO_FILTER)
    ) router_i (
        .rel_vld (rel_valid),
        .rel_idx (rel_idx),
        .dest    (rel_dest)
    );

    regfree_pool #(
        .DEPTH     (NUM_INT),
        .IDX_W     (IDX_W),
        .PRELOAD   (NUM_INT - NUM_LOG_INT),
        .FIRST_IDX (NUM_LOG_INT)
    ) int_pool_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (int_alloc_valid),
        .head_idx  (int_alloc_idx),
        .empty     (int_empty),
        .count     (int_free_cnt),
        .push0_vld (rel_dest == DEST_INT),
        .push0_idx (rel_idx),
        .push1_vld (int_rel_valid),
        .push1_idx (int_rel_idx),
        .under_err (int_alloc_err),
        .over_err  (int_ovf_err)
    );

    regfree_pool #(
        .DEPTH     (NUM_FP),
        .IDX_W     (IDX_W),
        .PRELOAD   (NUM_FP - NUM_LOG_FP),
        .FIRST_IDX (NUM_INT + NUM_LOG_FP)
    ) fp_pool_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (fp_alloc_valid),
        .head_idx  (fp_alloc_idx),
        .empty     (fp_empty),
        .count     (fp_free_cnt),
        .push0_vld (rel_dest == DEST_FP),
        .push0_idx (rel_idx),
        .push1_vld (fp_rel_valid),
        .push1_idx (fp_rel_idx),
        .under_err (fp_alloc_err),
        .over_err  (fp_ovf_err)
    );

    assign int_alloc_ready = !int_empty;
    assign fp_alloc_ready  = !fp_empty;

endmodule

// File: rtl/regfree_dual_pool_chk.sv
module regfree_dual_pool_chk #(
    parameter int NUM_INT        = 16,
    parameter int NUM_FP         = 12,
    parameter int ZERO_REG       = 0,
    parameter bit FP_ZERO_FILTER = 1'b1,
    parameter int IDX_W          = 5,
    parameter int INT_CNT_W      = 5,
    parameter int FP_CNT_W       = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 int_alloc_valid,
    input logic                 int_alloc_ready,
    input logic                 fp_alloc_valid,
    input logic                 fp_alloc_ready,
    input logic                 rel_valid,
    input logic [IDX_W-1:0]     rel_idx,
    input logic                 int_rel_valid,
    input logic                 fp_rel_valid,
    input logic [INT_CNT_W-1:0] int_free_cnt,
    input logic [FP_CNT_W-1:0]  fp_free_cnt,
    input logic                 int_alloc_err,
    input logic                 fp_alloc_err
);

    localparam logic [IDX_W-1:0] INT_ZERO = IDX_W'(ZERO_REG);
    localparam logic [IDX_W-1:0] FP_ZERO  = IDX_W'(ZERO_REG + NUM_INT);

    assert_int_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_free_cnt <= INT_CNT_W'(NUM_INT));

    assert_fp_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fp_free_cnt <= FP_CNT_W'(NUM_FP));

    assert_int_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_alloc_valid && int_alloc_ready && !rel_valid && !int_rel_valid)
        |=> int_free_cnt == $past(int_free_cnt) - 1'b1);

    assert_int_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_alloc_valid && !int_alloc_ready) |=> int_alloc_err);

    assert_fp_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_alloc_valid && !fp_alloc_ready) |=> fp_alloc_err);

    assert_int_zero_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && rel_idx == INT_ZERO && !int_rel_valid && !int_alloc_valid)
        |=> $stable(int_free_cnt));

    assert_fp_zero_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (FP_ZERO_FILTER && rel_valid && rel_idx == FP_ZERO && !fp_rel_valid && !fp_alloc_valid)
        |=> $stable(fp_free_cnt));

    assert_int_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_alloc_valid && int_alloc_ready && int_rel_valid && !rel_valid)
        |=> $stable(int_free_cnt));

endmodule

bind regfree_dual_pool regfree_dual_pool_chk #(
    .NUM_INT        (NUM_INT),
    .NUM_FP         (NUM_FP),
    .ZERO_REG       (ZERO_REG),
    .FP_ZERO_FILTER (FP_ZERO_FILTER),
    .IDX_W          (IDX_W),
    .INT_CNT_W      (INT_CNT_W),
    .FP_CNT_W       (FP_CNT_W)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .int_alloc_valid (int_alloc_valid),
    .int_alloc_ready (int_alloc_ready),
    .fp_alloc_valid  (fp_alloc_valid),
    .fp_alloc_ready  (fp_alloc_ready),
    .rel_valid       (rel_valid),
    .rel_idx         (rel_idx),
    .int_rel_valid   (int_rel_valid),
    .fp_rel_valid    (fp_rel_valid),
    .int_free_cnt    (int_free_cnt),
    .fp_free_cnt     (fp_free_cnt),
    .int_alloc_err   (int_alloc_err),
    .fp_alloc_err    (fp_alloc_err)
);

// File: tb/regfree_dual_pool_tb_top.sv
module regfree_dual_pool_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_INT    = 16;
    localparam int NUM_FP     = 12;
    localparam int IDX_W      = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             int_alloc_valid = 1'b0;
    logic             int_alloc_ready;
    logic [IDX_W-1:0] int_alloc_idx;
    logic             fp_alloc_valid = 1'b0;
    logic             fp_alloc_ready;
    logic [IDX_W-1:0] fp_alloc_idx;
    logic             rel_valid = 1'b0;
    logic [IDX_W-1:0] rel_idx = '0;
    logic             int_rel_valid = 1'b0;
    logic [IDX_W-1:0] int_rel_idx = '0;
    logic             fp_rel_valid = 1'b0;
    logic [IDX_W-1:0] fp_rel_idx = '0;
    logic             int_empty;
    logic [4:0]       int_free_cnt;
    logic             fp_empty;
    logic [3:0]       fp_free_cnt;
    logic             int_alloc_err, fp_alloc_err, int_ovf_err, fp_ovf_err;

    int tests = 0;
    int fails = 0;

    // Shared-port vectors: {index, integer count step, fp count step}
    localparam logic [6:0] REL_VEC [8] = '{
        {5'd5,  1'b1, 1'b0},
        {5'd0,  1'b0, 1'b0},
        {5'd16, 1'b0, 1'b0},
        {5'd20, 1'b0, 1'b1},
        {5'd3,  1'b1, 1'b0},
        {5'd28, 1'b0, 1'b0},
        {5'd31, 1'b0, 1'b0},
        {5'd17, 1'b0, 1'b1}
    };

    regfree_dual_pool dut_i (
        .clk(clk), .rst_n(rst_n),
        .int_alloc_valid(int_alloc_valid), .int_alloc_ready(int_alloc_ready),
        .int_alloc_idx(int_alloc_idx),
        .fp_alloc_valid(fp_alloc_valid), .fp_alloc_ready(fp_alloc_ready),
        .fp_alloc_idx(fp_alloc_idx),
        .rel_valid(rel_valid), .rel_idx(rel_idx),
        .int_rel_valid(int_rel_valid), .int_rel_idx(int_rel_idx),
        .fp_rel_valid(fp_rel_valid), .fp_rel_idx(fp_rel_idx),
        .int_empty(int_empty), .int_free_cnt(int_free_cnt),
        .fp_empty(fp_empty), .fp_free_cnt(fp_free_cnt),
        .int_alloc_err(int_alloc_err), .fp_alloc_err(fp_alloc_err),
        .int_ovf_err(int_ovf_err), .fp_ovf_err(fp_ovf_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ic, fc;
        tick();
        tick();
        rst_n = 1'b1;

        // R1 reset contents
        chk("R1 int count after reset", int_free_cnt, NUM_INT - 8);
        chk("R1 fp count after reset", fp_free_cnt, NUM_FP - 8);
        chk("R1 int head after reset", int_alloc_idx, 8);
        chk("R1 fp head after reset", fp_alloc_idx, NUM_INT + 8);
        chk("R1 error outputs after reset",
            {int_alloc_err, fp_alloc_err, int_ovf_err, fp_ovf_err}, 0);
        chk("R7 int empty flag after reset", int_empty, 0);

        // R3 R4 R5 shared-port routing vectors
        for (int v = 0; v < 8; v++) begin
            ic = int_free_cnt;
            fc = fp_free_cnt;
            rel_valid = 1'b1;
            rel_idx   = REL_VEC[v][6:2];
            tick();
            rel_valid = 1'b0;
            chk($sformatf("R3 R4 int step for index %0d", REL_VEC[v][6:2]),
                int_free_cnt, ic + REL_VEC[v][1]);
            chk($sformatf("R3 R5 fp step for index %0d", REL_VEC[v][6:2]),
                fp_free_cnt, fc + REL_VEC[v][0]);
        end

        // R8 idle cycle: no removal without valid
        tick();
        chk("R8 int count stable when idle", int_free_cnt, 10);

        // R2 R8 drain integer pool in order
        for (int k = 0; k < 10; k++) begin
            chk("R8 int ready while nonempty", int_alloc_ready, 1);
            chk($sformatf("R2 int order slot %0d", k), int_alloc_idx,
                (k < 8) ? 8 + k : ((k == 8) ? 5 : 3));
            int_alloc_valid = 1'b1;
            tick();
            int_alloc_valid = 1'b0;
        end
        chk("R7 int empty after drain", int_empty, 1);
        chk("R7 int count after drain", int_free_cnt, 0);
        chk("R8 int ready low when empty", int_alloc_ready, 0);

        // R9 allocate while empty
        int_alloc_valid = 1'b1;
        tick();
        int_alloc_valid = 1'b0;
        chk("R9 int alloc error pulse", int_alloc_err, 1);
        chk("R9 int count unchanged on empty request", int_free_cnt, 0);
        tick();
        chk("R9 int alloc error clears", int_alloc_err, 0);

        // R2 fp order: preloaded first, then released
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R2 fp order slot %0d", k), fp_alloc_idx, NUM_INT + 8 + k);
            fp_alloc_valid = 1'b1;
            tick();
            fp_alloc_valid = 1'b0;
        end
        chk("R2 fp head after preload drained", fp_alloc_idx, 20);
        chk("R7 fp count after partial drain", fp_free_cnt, 2);

        // R6 direct ports skip filtering
        int_rel_valid = 1'b1;
        int_rel_idx   = 5'd0;
        fp_rel_valid  = 1'b1;
        fp_rel_idx    = 5'd3;
        tick();
        int_rel_valid = 1'b0;
        fp_rel_valid  = 1'b0;
        chk("R6 direct int accepts zero index", int_free_cnt, 1);
        chk("R6 direct int head", int_alloc_idx, 0);
        chk("R6 direct fp accepts out-of-range index", fp_free_cnt, 3);

        // R10 allocate and release together
        int_alloc_valid = 1'b1;
        int_rel_valid   = 1'b1;
        int_rel_idx     = 5'd7;
        tick();
        int_alloc_valid = 1'b0;
        int_rel_valid   = 1'b0;
        chk("R10 int count unchanged on swap", int_free_cnt, 1);
        chk("R10 int head after swap", int_alloc_idx, 7);

        // R11 fill integer pool
        for (int k = 1; k <= 14; k++) begin
            int_rel_valid = 1'b1;
            int_rel_idx   = IDX_W'(k);
            tick();
        end
        int_rel_valid = 1'b0;
        chk("R11 int count before last slot", int_free_cnt, 15);
        rel_valid     = 1'b1;
        rel_idx       = 5'd9;
        int_rel_valid = 1'b1;
        int_rel_idx   = 5'd10;
        tick();
        rel_valid     = 1'b0;
        int_rel_valid = 1'b0;
        chk("R11 int count at full", int_free_cnt, 16);
        chk("R11 overflow pulse on double push", int_ovf_err, 1);
        int_rel_valid = 1'b1;
        int_rel_idx   = 5'd11;
        tick();
        int_rel_valid = 1'b0;
        chk("R11 overflow pulse on full push", int_ovf_err, 1);
        chk("R11 int count stays full", int_free_cnt, 16);
        tick();
        chk("R11 overflow clears", int_ovf_err, 0);
        for (int k = 0; k < 16; k++) begin
            chk($sformatf("R11 int order after fill slot %0d", k), int_alloc_idx,
                (k == 0) ? 7 : ((k == 15) ? 9 : k));
            int_alloc_valid = 1'b1;
            tick();
            int_alloc_valid = 1'b0;
        end
        chk("R7 int empty after full drain", int_empty, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule